// File: doc/BRIEF.md
# 16-bit ALU with Registered NZCV Flags

This block is the execute-stage arithmetic and logic unit of a small load/store processor. Each cycle it receives a 4-bit function code, a destination operand and a source operand. The source operand is either a register value or an 8-bit immediate widened to 16 bits. The block returns a 16-bit result, a write-enable for the destination register, and the flag values that the operation would produce. Those flag values are negative, zero, carry and overflow, packed as {N,Z,C,V} from bit 3 down to bit 0.

The flags sit in a register inside the block. Conditional branches read them, and the carry-using forms of add and subtract take the stored carry as their carry-in. The flag register loads only on a cycle where `valid_i` is high. Compare and test change only the flags and leave the register file untouched. The two top function codes are no-operations.

Function codes: 0 move, 1 add, 2 subtract, 3 add with carry, 4 subtract with carry, 5 compare, 6 or, 7 and, 8 xor, 9 shift left by one, 10 logical shift right by one, 11 arithmetic shift right by one, 12 move, 13 test, 14 and 15 no-op. The shifts act on the destination operand and ignore the source.

Top module: `alu16_flags`

## Requirements
- R1: Codes 0 and 12 drive the source operand unchanged onto `result_o`, assert the write-enable and leave all four flags unchanged.
- R2: When `use_imm_i` is 1, the source operand is `imm_i` zero-extended to 16 bits, and `src_reg_i` has no effect. When `use_imm_i` is 0, the source operand is `src_reg_i`.
- R3: Add (1) gives dst+src, and subtract (2) gives dst-src, modulo 2^16. For add, C is the carry out. For subtract, C is 1 exactly when no borrow occurs (dst >= src unsigned). V is 1 on two's-complement overflow.
- R4: Add with carry (3) gives dst+src+C. Subtract with carry (4) gives dst-src-(1-C). In both, C is the stored carry flag. C and V are formed from the full operation as in R3.
- R5: Compare (5) produces the flags of dst-src, and test (13) produces the flags of dst AND src. Both hold the write-enable low.
- R6: Or (6), and (7) and xor (8) write the bitwise result and update N and Z. They leave C and V unchanged.
- R7: Shift left (9) gives dst<<1 with C = dst[15]. Logical shift right (10) gives dst>>1 with C = dst[0]. Arithmetic shift right (11) gives {dst[15],dst[15:1]} with C = dst[0]. All three update N and Z and leave V unchanged.
- R8: Codes 14 and 15 hold the write-enable low and leave all four flags unchanged.
- R9: For every flag-updating code, N equals bit 15 of the computed value and Z is 1 exactly when the computed 16-bit value is zero.
- R10: `flags_nxt_o` shows the flags the current operation would produce. `flags_o` takes that value at the next rising edge only if `valid_i` is high, and otherwise holds. `wr_en_o` is low whenever `valid_i` is low.
- R11: While `rst_n` is low, the flag register clears to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| valid_i | input | 1 | Operation is issued this cycle |
| fn_i | input | 4 | Function code |
| use_imm_i | input | 1 | Select immediate as source operand |
| dst_i | input | 16 | Destination register operand |
| src_reg_i | input | 16 | Source register operand |
| imm_i | input | 8 | 8-bit immediate constant |
| result_o | output | 16 | Computed result |
| wr_en_o | output | 1 | Destination register write-enable |
| flags_nxt_o | output | 4 | Flags the operation would produce, {N,Z,C,V} |
| flags_o | output | 4 | Registered flags, {N,Z,C,V} |

## Verification
The bench builds the block with its default widths: a 16-bit datapath and an 8-bit immediate. At these widths a bench model written in integer arithmetic can reach the exact carry and overflow boundaries. Directed operands cover 0x7FFF, 0x8000, 0xFFFF and equal values, and a stored carry of both polarities drives the carry-using forms. Random stimulus mixes every function code with immediate selection and idle cycles. This checks that idle cycles, compare, test and the no-op codes leave the flags or the register write as required.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  localparam int FN_W   = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_MOV   = 4'd0,
    FN_ADD   = 4'd1,
    FN_SUB   = 4'd2,
    FN_ADC   = 4'd3,
    FN_SBC   = 4'd4,
    FN_CMP   = 4'd5,
    FN_OR    = 4'd6,
    FN_AND   = 4'd7,
    FN_XOR   = 4'd8,
    FN_SHL   = 4'd9,
    FN_LSR   = 4'd10,
    FN_ASR   = 4'd11,
    FN_MOV2  = 4'd12,
    FN_TST   = 4'd13,
    FN_NOP14 = 4'd14,
    FN_NOP15 = 4'd15
  } alu_fn_e;

  // flag word, bit 3 down to bit 0: N Z C V
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/alu16_src_sel.sv
module alu16_src_sel #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] src_o
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_wide;

  generate
    if (PAD_W > 0) begin : g_zext
      assign imm_wide = {{PAD_W{1'b0}}, imm_i};
    end else begin : g_trunc
      assign imm_wide = imm_i[DATA_W-1:0];
    end
  endgenerate

  assign src_o = use_imm_i ? imm_wide : reg_i;
endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [FN_W-1:0]   fn_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  nzcv_t             flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_o,
  output logic              upd_o,
  output nzcv_t             flags_nxt_o,
  output logic              cls_arith_o,
  output logic              cls_logic_o,
  output logic              cls_shift_o
);
  localparam int MSB = DATA_W - 1;

  // carry-propagating adder: a + b + ci, with the carry out on top
  function automatic logic [DATA_W:0] add_ci(input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b,
                                             input logic ci);
    return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, ci};
  endfunction

  // overflow when both addends agree in sign and the sum differs
  function automatic logic ovf(input logic a_s, input logic b_s, input logic r_s);
    return (a_s == b_s) && (r_s != a_s);
  endfunction

  alu_fn_e           fn;
  logic              neg_b;
  logic              cin;
  logic [DATA_W-1:0] b_op;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] flag_val;

  assign fn = alu_fn_e'(fn_i);

  always_comb begin
    neg_b = (fn == FN_SUB) || (fn == FN_SBC) || (fn == FN_CMP);
    unique case (fn)
      FN_ADD:                cin = 1'b0;
      FN_SUB, FN_CMP:        cin = 1'b1;
      FN_ADC, FN_SBC:        cin = flags_i.c;
      default:               cin = 1'b0;
    endcase
    b_op = neg_b ? ~src_i : src_i;
    sum  = add_ci(dst_i, b_op, cin);
  end

  always_comb begin
    cls_arith_o = 1'b0;
    cls_logic_o = 1'b0;
    cls_shift_o = 1'b0;
    result_o    = dst_i;
    flag_val    = dst_i;
    wr_o        = 1'b1;
    upd_o       = 1'b1;
    flags_nxt_o = flags_i;
    unique case (fn)
      FN_MOV, FN_MOV2: begin
        result_o = src_i;
        upd_o    = 1'b0;
      end
      FN_ADD, FN_SUB, FN_ADC, FN_SBC, FN_CMP: begin
        cls_arith_o   = 1'b1;
        result_o      = sum[MSB:0];
        flag_val      = sum[MSB:0];
        wr_o          = (fn != FN_CMP);
        flags_nxt_o.c = sum[DATA_W];
        flags_nxt_o.v = ovf(dst_i[MSB], b_op[MSB], sum[MSB]);
      end
      FN_OR: begin
        cls_logic_o = 1'b1;
        result_o    = dst_i | src_i;
        flag_val    = result_o;
      end
      FN_AND, FN_TST: begin
        cls_logic_o = 1'b1;
        result_o    = dst_i & src_i;
        flag_val    = result_o;
        wr_o        = (fn != FN_TST);
      end
      FN_XOR: begin
        cls_logic_o = 1'b1;
        result_o    = dst_i ^ src_i;
        flag_val    = result_o;
      end
      FN_SHL: begin
        cls_shift_o   = 1'b1;
        result_o      = {dst_i[MSB-1:0], 1'b0};
        flag_val      = result_o;
        flags_nxt_o.c = dst_i[MSB];
      end
      FN_LSR: begin
        cls_shift_o   = 1'b1;
        result_o      = {1'b0, dst_i[MSB:1]};
        flag_val      = result_o;
        flags_nxt_o.c = dst_i[0];
      end
      FN_ASR: begin
        cls_shift_o   = 1'b1;
        result_o      = {dst_i[MSB], dst_i[MSB:1]};
        flag_val      = result_o;
        flags_nxt_o.c = dst_i[0];
      end
      default: begin
        wr_o  = 1'b0;
        upd_o = 1'b0;
      end
    endcase
    if (upd_o) begin
      flags_nxt_o.n = flag_val[MSB];
      flags_nxt_o.z = (flag_val == '0);
    end
  end
endmodule

// File: rtl/alu16_flag_reg.sv
module alu16_flag_reg
  import alu16_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_i,
  input  nzcv_t d_i,
  output nzcv_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [3:0]        fn_i,
  input  logic              use_imm_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_reg_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_nxt_o,
  output logic [3:0]        flags_o
);
  logic [DATA_W-1:0] src_op;
  logic              core_wr;
  logic              core_upd;
  logic              flag_load;
  logic              cls_arith;
  logic              cls_logic;
  logic              cls_shift;
  nzcv_t             flags_q;
  nzcv_t             flags_d;

  alu16_src_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_src (
    .use_imm_i (use_imm_i),
    .reg_i     (src_reg_i),
    .imm_i     (imm_i),
    .src_o     (src_op)
  );

  alu16_core #(.DATA_W(DATA_W)) u_core (
    .fn_i        (fn_i),
    .dst_i       (dst_i),
    .src_i       (src_op),
    .flags_i     (flags_q),
    .result_o    (result_o),
    .wr_o        (core_wr),
    .upd_o       (core_upd),
    .flags_nxt_o (flags_d),
    .cls_arith_o (cls_arith),
    .cls_logic_o (cls_logic),
    .cls_shift_o (cls_shift)
  );

  assign flag_load = valid_i & core_upd;

  alu16_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (flag_load),
    .d_i    (flags_d),
    .q_o    (flags_q)
  );

  assign wr_en_o     = valid_i & core_wr;
  assign flags_nxt_o = flags_d;
  assign flags_o     = flags_q;
endmodule

// File: rtl/alu16_chk.sv
module alu16_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [3:0]        fn_i,
  input logic [DATA_W-1:0] src_op,
  input logic [DATA_W-1:0] result_o,
  input logic              wr_en_o,
  input logic [3:0]        flags_nxt_o,
  input logic [3:0]        flags_o,
  input logic              cls_logic,
  input logic              cls_shift
);
  // R11
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> flags_o == 4'b0000);

  // R10
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(flags_o));

  // R10
  flags_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> flags_o == $past(flags_nxt_o));

  // R10
  idle_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> !wr_en_o);

  // R5
  flag_only_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == 4'd5 || fn_i == 4'd13) |-> !wr_en_o);

  // R8
  nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == 4'd14 || fn_i == 4'd15) |-> (!wr_en_o && flags_nxt_o == flags_o));

  // R1
  move_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_i == 4'd0 || fn_i == 4'd12) |-> (result_o == src_op && flags_nxt_o == flags_o));

  // R6
  logic_cv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cls_logic) |=> flags_o[1:0] == $past(flags_o[1:0]));

  // R7
  shift_v_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && cls_shift) |=> flags_o[0] == $past(flags_o[0]));
endmodule

bind alu16_flags alu16_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .fn_i        (fn_i),
  .src_op      (src_op),
  .result_o    (result_o),
  .wr_en_o     (wr_en_o),
  .flags_nxt_o (flags_nxt_o),
  .flags_o     (flags_o),
  .cls_logic   (cls_logic),
  .cls_shift   (cls_shift)
);

// File: tb/sim_alu16_flags.sv
`timescale 1ns/1ps
module sim_alu16_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  fn_i = 4'd0;
  logic        use_imm_i = 1'b0;
  logic [15:0] dst_i = 16'd0;
  logic [15:0] src_reg_i = 16'd0;
  logic [7:0]  imm_i = 8'd0;
  logic [15:0] result_o;
  logic        wr_en_o;
  logic [3:0]  flags_nxt_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int fails = 0;
  logic [3:0] mflags = 4'b0000;
  bit done = 0;

  always #2 clk = ~clk;

  alu16_flags u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .fn_i(fn_i),
    .use_imm_i(use_imm_i), .dst_i(dst_i), .src_reg_i(src_reg_i),
    .imm_i(imm_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .flags_nxt_o(flags_nxt_o), .flags_o(flags_o)
  );

  function automatic string tag_of(input logic [3:0] f);
    case (f)
      4'd0, 4'd12:                return "R1";
      4'd1, 4'd2:                 return "R3";
      4'd3, 4'd4:                 return "R4";
      4'd5, 4'd13:                return "R5";
      4'd6, 4'd7, 4'd8:           return "R6";
      4'd9, 4'd10, 4'd11:         return "R7";
      default:                    return "R8";
    endcase
  endfunction

  // model returns {result[15:0], wr, N, Z, C, V}
  function automatic logic [20:0] model(input logic [3:0] f, input logic [15:0] d,
                                        input logic [15:0] s, input logic [3:0] fl);
    int w; int sw; int sd; int ss;
    logic [15:0] r; logic n, z, c, v, wr, upd;
    n = fl[3]; z = fl[2]; c = fl[1]; v = fl[0];
    r = d; wr = 1'b1; upd = 1'b1;
    sd = int'($signed(d)); ss = int'($signed(s));
    w = 0; sw = 0;
    case (f)
      4'd0, 4'd12: begin r = s; upd = 1'b0; end
      4'd1: begin w = int'(d) + int'(s); sw = sd + ss; end
      4'd2, 4'd5: begin w = int'(d) - int'(s); sw = sd - ss; end
      4'd3: begin w = int'(d) + int'(s) + int'(fl[1]); sw = sd + ss + int'(fl[1]); end
      4'd4: begin w = int'(d) - int'(s) - (1 - int'(fl[1])); sw = sd - ss - (1 - int'(fl[1])); end
      4'd6: r = d | s;
      4'd7, 4'd13: r = d & s;
      4'd8: r = d ^ s;
      4'd9:  begin r = d << 1; c = d[15]; end
      4'd10: begin r = d >> 1; c = d[0]; end
      4'd11: begin r = {d[15], d[15:1]}; c = d[0]; end
      default: begin wr = 1'b0; upd = 1'b0; end
    endcase
    if (f >= 4'd1 && f <= 4'd5) begin
      r = w[15:0];
      if (f == 4'd1 || f == 4'd3) c = (w > 65535);
      else c = (w >= 0);
      v = (sw > 32767) || (sw < -32768);
    end
    if (f == 4'd5 || f == 4'd13) wr = 1'b0;
    if (upd) begin n = r[15]; z = (r == 16'd0); end
    return {r, wr, n, z, c, v};
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s fn=%0d actual=%h expected=%h", tag, what, fn_i, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] f, input logic imm_sel, input logic [15:0] d,
                        input logic [15:0] sreg, input logic [7:0] im, input logic vld);
    logic [15:0] s; logic [20:0] m;
    @(negedge clk);
    fn_i = f; use_imm_i = imm_sel; dst_i = d; src_reg_i = sreg; imm_i = im; valid_i = vld;
    s = imm_sel ? {8'h00, im} : sreg;   // R2 zero extension
    m = model(f, d, s, mflags);
    #1;
    if (m[4]) check(imm_sel ? "R2" : tag_of(f), "result", result_o, m[20:5]);
    check(vld ? tag_of(f) : "R10", "wr_en", {15'd0, wr_en_o}, {15'd0, m[4] & vld});
    check(tag_of(f), "flags_nxt R9", {12'd0, flags_nxt_o}, {12'd0, m[3:0]});
    @(posedge clk); #1;
    if (vld) mflags = m[3:0];
    check("R10", "flags_o", {12'd0, flags_o}, {12'd0, mflags});
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset flags", {12'd0, flags_o}, 16'd0);
    rst_n = 1'b1;
    // directed corners
    run_op(4'd1, 0, 16'h7FFF, 16'h0001, 8'h00, 1);  // R3 signed overflow
    run_op(4'd1, 0, 16'hFFFF, 16'h0001, 8'h00, 1);  // R3 carry, zero
    run_op(4'd3, 0, 16'h0001, 16'h0001, 8'h00, 1);  // R4 carry in set
    run_op(4'd2, 0, 16'h0005, 16'h0005, 8'h00, 1);  // R3 no borrow equal
    run_op(4'd2, 0, 16'h8000, 16'h0001, 8'h00, 1);  // R3 overflow on sub
    run_op(4'd2, 0, 16'h0000, 16'h0001, 8'h00, 1);  // R3 borrow -> C=0
    run_op(4'd4, 0, 16'h0003, 16'h0001, 8'h00, 1);  // R4 with C=0
    run_op(4'd5, 1, 16'h0080, 16'hFFFF, 8'h80, 1);  // R5 R2 immediate compare
    run_op(4'd13, 0, 16'hF0F0, 16'h0F0F, 8'h00, 1); // R5 test zero
    run_op(4'd6, 0, 16'h8000, 16'h0001, 8'h00, 1);  // R6
    run_op(4'd9, 0, 16'h8001, 16'h0000, 8'h00, 1);  // R7 shl carry out
    run_op(4'd10, 0, 16'h8001, 16'h0000, 8'h00, 1); // R7 lsr
    run_op(4'd11, 0, 16'h8001, 16'h0000, 8'h00, 1); // R7 asr sign kept
    run_op(4'd12, 1, 16'h1234, 16'hBEEF, 8'hA5, 1); // R1 R2 move immediate
    run_op(4'd0, 0, 16'h1234, 16'hBEEF, 8'hA5, 1);  // R1 move register
    run_op(4'd14, 0, 16'h0000, 16'h0000, 8'h00, 1); // R8
    run_op(4'd15, 0, 16'hFFFF, 16'h0001, 8'h00, 1); // R8
    run_op(4'd1, 0, 16'h0000, 16'h0000, 8'h00, 0);  // R10 idle holds
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d; logic [15:0] s;
      d = $urandom();
      s = $urandom();
      if ($urandom_range(0, 7) == 0) d = ($urandom_range(0, 1) != 0) ? 16'h7FFF : 16'h8000;
      if ($urandom_range(0, 7) == 0) s = d;
      run_op(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), d, s,
             8'($urandom()), ($urandom_range(0, 5) != 0));
    end
    // R11 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    valid_i = 1'b0;
    @(posedge clk); #1;
    check("R11", "reset flags again", {12'd0, flags_o}, 16'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule